// File: doc/BRIEF.md
# Integer Execution Unit with Condition Codes

The block is the integer datapath of a 32-bit scalar core. It combines a first source register with a second operand and produces a 32-bit result in the same cycle. The second operand is either a register value or a 13-bit immediate, widened with its sign bit. The operation set covers:

- add and subtract, each with a form that also adds or subtracts the stored carry;
- AND, OR and XOR, their inverted-operand forms, and XNOR;
- three shifts;
- placing a wide constant in the upper bits;
- reading and writing an auxiliary Y register.

Four condition codes (negative, zero, overflow, carry) are held in a register beside the datapath. An operation changes them only when the set-flags input is high. The carry-chained forms read the stored carry, so several narrow additions can be linked into one wider sum over consecutive cycles. The Y register keeps a value between instructions. It is written with the XOR of the two operands and read back through the result bus.

Top module: `int_alu`

## Requirements
- R1: When use_imm_i is 1 the second operand is imm_i sign-extended from bit 12 to 32 bits; otherwise it is rs2_i.
- R2: Opcode 0 yields rs1+op2 and opcode 1 yields rs1-op2. With set_cc_i high, C takes the carry out (add) or the borrow (subtract), and V is set on signed overflow of the 32-bit result.
- R3: Opcode 2 yields rs1+op2+C and opcode 3 yields rs1-op2-C, using the stored C flag.
- R4: Opcodes 4..9 yield AND, OR, XOR, XNOR, rs1 AND NOT op2, and rs1 OR NOT op2, in that order.
- R5: Opcodes 10, 11 and 12 shift rs1 left logically, right logically and right arithmetically. The shift amount is op2 bits 4:0, and the higher bits of op2 are ignored.
- R6: Opcode 13 yields hi_i in bits 31:10 and zeros in bits 9:0.
- R7: Opcode 15 stores rs1 XOR op2 into Y and also drives that value as the result. Opcode 14 returns the contents of Y.
- R8: flags_o is {N,Z,V,C} in bits 3..0. On an update, N takes result bit 31 and Z is 1 exactly when the result is zero. The update is visible after the next rising clock edge.
- R9: Opcodes 4..12 with set_cc_i high clear V and C.
- R10: With set_cc_i low, flags_o is unchanged. Opcodes 13, 14 and 15 leave flags_o unchanged whatever set_cc_i is.
- R11: While rst_ni is low, flags_o is 0 and Y is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Operation select |
| set_cc_i | input | 1 | Update the condition codes |
| rs1_i | input | 32 | First source operand |
| rs2_i | input | 32 | Second source register value |
| use_imm_i | input | 1 | Select the immediate as the second operand |
| imm_i | input | 13 | Signed immediate |
| hi_i | input | 22 | Upper constant for opcode 13 |
| result_o | output | 32 | Combinational result |
| flags_o | output | 4 | Registered {N,Z,V,C} |

## Verification
The hardest case to reach is a carry-chained operation whose outcome depends on the stored carry. The flag must first be put into a known state by an earlier flag-setting operation, and no later operation may disturb it before the chained one. The vector table is therefore ordered so that each extended add or subtract follows an operation that sets C to a chosen value. A plain add that would have changed C is placed in between to show that C is retained. Y reads follow Y writes in the same way, including a write whose operand is a negative immediate, and a reset in the middle of the run shows that Y and the flags return to zero.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,  OP_SUB  = 4'd1,  OP_ADDC = 4'd2,  OP_SUBC = 4'd3,
    OP_AND  = 4'd4,  OP_OR   = 4'd5,  OP_XOR  = 4'd6,  OP_XNOR = 4'd7,
    OP_ANDN = 4'd8,  OP_ORN  = 4'd9,  OP_SLL  = 4'd10, OP_SRL  = 4'd11,
    OP_SRA  = 4'd12, OP_HI   = 4'd13, OP_RDY  = 4'd14, OP_WRY  = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } cc_t;

  function automatic logic op_is_arith(alu_op_e op);
    return op inside {OP_ADD, OP_SUB, OP_ADDC, OP_SUBC};
  endfunction

  // ops whose flag-setting form exists
  function automatic logic op_sets_cc(alu_op_e op);
    return op <= OP_SRA;
  endfunction
endpackage

// File: rtl/alu_opsel.sv
module alu_opsel #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 13
) (
  input  logic [DATA_W-1:0] rs2_i,
  input  logic              use_imm_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic [DATA_W-1:0] op2_o
);
  localparam int EXT_W = DATA_W - IMM_W;

  always_comb begin
    if (use_imm_i) op2_o = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
    else           op2_o = rs2_i;
  end
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sub_i,
  input  logic              cin_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              c_o,
  output logic              v_o
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] b_eff;
  logic              ci;
  logic [DATA_W:0]   full;

  // subtract as a + ~b + 1 - cin; borrow is the inverted carry out
  always_comb begin
    b_eff = sub_i ? ~b_i : b_i;
    ci    = sub_i ? ~cin_i : cin_i;
    full  = {1'b0, a_i} + {1'b0, b_eff} + {{DATA_W{1'b0}}, ci};
    sum_o = full[DATA_W-1:0];
    c_o   = sub_i ? ~full[DATA_W] : full[DATA_W];
    v_o   = (a_i[MSB] == b_eff[MSB]) && (sum_o[MSB] != a_i[MSB]);
  end
endmodule

// File: rtl/alu_bitops.sv
module alu_bitops
  import alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o
);
  localparam int SH_W = $clog2(DATA_W);

  logic [SH_W-1:0] sh;

  always_comb begin
    sh = b_i[SH_W-1:0];
    unique case (op_i)
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      OP_XNOR: res_o = ~(a_i ^ b_i);
      OP_ANDN: res_o = a_i & ~b_i;
      OP_ORN:  res_o = a_i | ~b_i;
      OP_SLL:  res_o = a_i << sh;
      OP_SRL:  res_o = a_i >> sh;
      OP_SRA:  res_o = DATA_W'($signed(a_i) >>> sh);
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/alu_state.sv
module alu_state
  import alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cc_we_i,
  input  cc_t               cc_d_i,
  input  logic              y_we_i,
  input  logic [DATA_W-1:0] y_d_i,
  output cc_t               cc_q_o,
  output logic [DATA_W-1:0] y_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cc_q_o <= '0;
    else if (cc_we_i) cc_q_o <= cc_d_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     y_q_o <= '0;
    else if (y_we_i) y_q_o <= y_d_i;
  end
endmodule

// File: rtl/int_alu.sv
module int_alu
  import alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 13,
  parameter int HI_W   = 22
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        op_i,
  input  logic              set_cc_i,
  input  logic [DATA_W-1:0] rs1_i,
  input  logic [DATA_W-1:0] rs2_i,
  input  logic              use_imm_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [HI_W-1:0]   hi_i,
  output logic [DATA_W-1:0] result_o,
  output logic [3:0]        flags_o
);
  localparam int LO_W = DATA_W - HI_W;

  alu_op_e           op;
  logic [DATA_W-1:0] op2, sum, bit_res, y_q;
  logic              add_c, add_v, is_sub, chain;
  cc_t               cc_q, cc_d;

  assign op     = alu_op_e'(op_i);
  assign is_sub = (op == OP_SUB) || (op == OP_SUBC);
  assign chain  = (op == OP_ADDC) || (op == OP_SUBC);

  alu_opsel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opsel (
    .rs2_i(rs2_i), .use_imm_i(use_imm_i), .imm_i(imm_i), .op2_o(op2)
  );

  alu_addsub #(.DATA_W(DATA_W)) u_addsub (
    .a_i(rs1_i), .b_i(op2), .sub_i(is_sub), .cin_i(chain & cc_q.c),
    .sum_o(sum), .c_o(add_c), .v_o(add_v)
  );

  alu_bitops #(.DATA_W(DATA_W)) u_bitops (
    .op_i(op), .a_i(rs1_i), .b_i(op2), .res_o(bit_res)
  );

  always_comb begin
    if (op_is_arith(op))  result_o = sum;
    else if (op == OP_HI) result_o = {hi_i, {LO_W{1'b0}}};
    else if (op == OP_RDY) result_o = y_q;
    else if (op == OP_WRY) result_o = rs1_i ^ op2;
    else                  result_o = bit_res;
  end

  always_comb begin
    cc_d.n = result_o[DATA_W-1];
    cc_d.z = (result_o == '0);
    cc_d.v = op_is_arith(op) & add_v;
    cc_d.c = op_is_arith(op) & add_c;
  end

  alu_state #(.DATA_W(DATA_W)) u_state (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cc_we_i(set_cc_i & op_sets_cc(op)), .cc_d_i(cc_d),
    .y_we_i(op == OP_WRY), .y_d_i(result_o),
    .cc_q_o(cc_q), .y_q_o(y_q)
  );

  assign flags_o = cc_q;
endmodule

// File: rtl/alu_chk.sv
module alu_chk
  import alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int HI_W   = 22
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [3:0]        op_i,
  input logic              set_cc_i,
  input logic [HI_W-1:0]   hi_i,
  input logic [DATA_W-1:0] result_o,
  input logic [3:0]        flags_o
);
  localparam int LO_W = DATA_W - HI_W;

  logic cc_op, logic_op;
  assign cc_op    = set_cc_i && (op_i <= 4'(OP_SRA));
  assign logic_op = cc_op && (op_i >= 4'(OP_AND));

  // R11
  reset_clear_chk: assert property (@(posedge clk_i) !rst_ni |-> flags_o == 4'd0);

  // R10
  keep_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cc_op |=> flags_o == $past(flags_o));

  // R8
  zero_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cc_op |=> flags_o[2] == ($past(result_o) == '0));

  // R8
  neg_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cc_op |=> flags_o[3] == $past(result_o[DATA_W-1]));

  // R9
  logic_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    logic_op |=> flags_o[1:0] == 2'b00);

  // R6
  hi_const_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == 4'(OP_HI) |-> result_o == {hi_i, {LO_W{1'b0}}});

  // R7
  y_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(op_i) == 4'(OP_WRY) && op_i == 4'(OP_RDY))
      |-> result_o == $past(result_o));
endmodule

bind int_alu alu_chk #(.DATA_W(DATA_W), .HI_W(HI_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .set_cc_i(set_cc_i),
  .hi_i(hi_i), .result_o(result_o), .flags_o(flags_o)
);

// File: tb/int_alu_test.sv
module int_alu_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op = '0;
  logic        set_cc = 1'b0;
  logic [31:0] rs1 = '0, rs2 = '0;
  logic        use_imm = 1'b0;
  logic [12:0] imm = '0;
  logic [21:0] hi = '0;
  logic [31:0] result;
  logic [3:0]  flags;
  int          n_chk = 0;
  int          n_bad = 0;

  always #5 clk = ~clk;

  int_alu uut (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .set_cc_i(set_cc),
    .rs1_i(rs1), .rs2_i(rs2), .use_imm_i(use_imm), .imm_i(imm),
    .hi_i(hi), .result_o(result), .flags_o(flags)
  );

  typedef struct packed {
    logic [3:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic        ui;
    logic [12:0] imm;
    logic [21:0] hi;
    logic        cc;
    logic [31:0] res;
    logic [3:0]  fl;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 29;
  // flags column is {N,Z,V,C} expected after the clock edge
  localparam vec_t VECS [NV] = '{
    '{4'd0,  32'h5,        32'h3,        1'b0, 13'h0,    22'h0,      1'b1, 32'h8,        4'h0, 8'd2},  // R2
    '{4'd0,  32'h7fffffff, 32'h1,        1'b0, 13'h0,    22'h0,      1'b1, 32'h80000000, 4'hA, 8'd2},  // R2 overflow
    '{4'd0,  32'hffffffff, 32'h0,        1'b1, 13'h0001, 22'h0,      1'b1, 32'h0,        4'h5, 8'd1},  // R1 carry out
    '{4'd2,  32'h1,        32'h2,        1'b0, 13'h0,    22'h0,      1'b1, 32'h4,        4'h0, 8'd3},  // R3 C=1
    '{4'd1,  32'h4,        32'h0,        1'b1, 13'h0004, 22'h0,      1'b1, 32'h0,        4'h4, 8'd8},  // R8 zero
    '{4'd1,  32'h3,        32'h5,        1'b0, 13'h0,    22'h0,      1'b1, 32'hfffffffe, 4'h9, 8'd2},  // R2 borrow
    '{4'd3,  32'ha,        32'h3,        1'b0, 13'h0,    22'h0,      1'b0, 32'h6,        4'h9, 8'd3},  // R3 sub chain
    '{4'd0,  32'hffffffff, 32'h1,        1'b0, 13'h0,    22'h0,      1'b0, 32'h0,        4'h9, 8'd10}, // R10 plain add
    '{4'd1,  32'h80000000, 32'h1,        1'b0, 13'h0,    22'h0,      1'b1, 32'h7fffffff, 4'h2, 8'd2},  // R2 sub overflow
    '{4'd1,  32'h0,        32'h1,        1'b0, 13'h0,    22'h0,      1'b1, 32'hffffffff, 4'h9, 8'd2},
    '{4'd3,  32'h5,        32'h2,        1'b0, 13'h0,    22'h0,      1'b1, 32'h2,        4'h0, 8'd3},  // R3
    '{4'd0,  32'ha,        32'h0,        1'b1, 13'h1fff, 22'h0,      1'b0, 32'h9,        4'h0, 8'd1},  // R1 imm -1
    '{4'd0,  32'h0,        32'h0,        1'b1, 13'h1000, 22'h0,      1'b0, 32'hfffff000, 4'h0, 8'd1},  // R1 imm min
    '{4'd0,  32'h80000000, 32'h80000000, 1'b0, 13'h0,    22'h0,      1'b1, 32'h0,        4'h7, 8'd2},
    '{4'd4,  32'hf0f0f0f0, 32'hff00ff00, 1'b0, 13'h0,    22'h0,      1'b1, 32'hf000f000, 4'h8, 8'd9},  // R9
    '{4'd5,  32'hf,        32'hf0,       1'b0, 13'h0,    22'h0,      1'b0, 32'hff,       4'h8, 8'd4},  // R4
    '{4'd6,  32'haaaa5555, 32'haaaa5555, 1'b0, 13'h0,    22'h0,      1'b1, 32'h0,        4'h4, 8'd4},
    '{4'd7,  32'h0,        32'h0,        1'b0, 13'h0,    22'h0,      1'b1, 32'hffffffff, 4'h8, 8'd4},
    '{4'd8,  32'hff,       32'hf,        1'b0, 13'h0,    22'h0,      1'b0, 32'hf0,       4'h8, 8'd4},
    '{4'd9,  32'h0,        32'hffffffff, 1'b0, 13'h0,    22'h0,      1'b1, 32'h0,        4'h4, 8'd4},
    '{4'd10, 32'h1,        32'h21,       1'b0, 13'h0,    22'h0,      1'b0, 32'h2,        4'h4, 8'd5},  // R5 low bits
    '{4'd11, 32'h80000000, 32'h1f,       1'b0, 13'h0,    22'h0,      1'b1, 32'h1,        4'h0, 8'd5},
    '{4'd12, 32'h80000000, 32'h4,        1'b0, 13'h0,    22'h0,      1'b0, 32'hf8000000, 4'h0, 8'd5},
    '{4'd12, 32'h7fffffff, 32'h0,        1'b1, 13'h001f, 22'h0,      1'b1, 32'h0,        4'h4, 8'd5},
    '{4'd13, 32'h12345678, 32'h0,        1'b0, 13'h0,    22'h3fffff, 1'b1, 32'hfffffc00, 4'h4, 8'd6},  // R6
    '{4'd15, 32'h12345678, 32'hffff,     1'b0, 13'h0,    22'h0,      1'b1, 32'h1234a987, 4'h4, 8'd7},  // R7
    '{4'd14, 32'h0,        32'h0,        1'b0, 13'h0,    22'h0,      1'b0, 32'h1234a987, 4'h4, 8'd7},
    '{4'd15, 32'h0,        32'h0,        1'b1, 13'h1fff, 22'h0,      1'b0, 32'hffffffff, 4'h4, 8'd7},
    '{4'd14, 32'h0,        32'h0,        1'b0, 13'h0,    22'h0,      1'b1, 32'hffffffff, 4'h4, 8'd10}  // R10 rdy+cc
  };

  task automatic check(input string what, input int req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL R0 watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("flags in reset", 11, 32'(flags), 32'h0);  // R11
    rst_n = 1'b1;
    op = 4'd14;
    #1 check("Y after reset", 11, result, 32'h0);    // R11
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      op = VECS[i].op; rs1 = VECS[i].a; rs2 = VECS[i].b;
      use_imm = VECS[i].ui; imm = VECS[i].imm; hi = VECS[i].hi; set_cc = VECS[i].cc;
      #1 check($sformatf("result v%0d", i), int'(VECS[i].req), result, VECS[i].res);
      @(posedge clk);
      #1 check($sformatf("flags v%0d", i), int'(VECS[i].req), 32'(flags), 32'(VECS[i].fl));
    end
    // mid-run reset returns Y and flags to zero (R11)
    @(negedge clk);
    op = 4'd14; set_cc = 1'b0; rst_n = 1'b0;
    #1 check("flags mid reset", 11, 32'(flags), 32'h0);
    check("Y mid reset", 11, result, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    summary();
  end
endmodule